// File: doc/BRIEF.md
# Touch-Panel Measurement Command Sequencer

This block holds a short list of touch-panel measurement commands and runs them against an analog front end. Each command is a 26-bit word that says which panel line the converter samples, which references it uses and which drive and ground switches are closed. The block passes the word to the front end without decoding it. Software builds the list through a single command register. Each read of that register rewinds the list. Each non-zero write adds one entry. A write whose command field is zero closes the list.

Once the touch engine is enabled and command-list mode is selected, the sequencer works through a run. It first waits a programmable settle time. It then converts every listed entry in write order, taking a programmable number of repeated samples per entry. The last sample of each entry becomes its result. At the end of a run all results are published at once and a ready flag is raised. Software drains the results as 32-bit words, each holding two 12-bit results. Runs repeat on their own for as long as the engine stays enabled.

The analog switching and the converter are outside the block. In their place there is a request strobe, the command word currently active, and a 12-bit sample input that the block captures on every conversion cycle.

Top module: `touch_cmd_seq`

## Requirements
- R1: After synchronous reset, every register reads 0, `touch_ready` is 0, `sample_req` is 0, `sample_cmd` is 0 and the command list is empty.
- R2: Any read of offset 0x24 returns 0 and rewinds the list pointer, so the next write becomes entry 0. A write to 0x24 whose bits 25:0 are not all zero stores those bits at the pointer and advances it, up to 6 entries; further such writes are ignored. A write whose bits 25:0 are all zero closes the list, setting its length to the number of entries stored. Bits 31:26 of a command write are discarded.
- R3: In every conversion cycle, `sample_cmd` equals the stored 26-bit command of the entry being converted. Within that word, bits 10:7 select the sampled input, bits 19:11 select the references and bits 25:20 close the switches. Outside conversion cycles `sample_cmd` is 0.
- R4: A run is laid out as follows. It begins with one idle cycle. Next come W+1 settle cycles, where W is the value of offset 0x14 when the run starts. Then, for each entry in write order, there are S+1 consecutive conversion cycles with `sample_req` high, where S is the value of offset 0x10. The run ends with one completion cycle. The entry's result is the `sample_data` value of its last conversion cycle.
- R5: Conversions take place only while bit 2 of offset 0x00 (engine enable) and bit 22 of offset 0x04 (list mode) are both set and the closed list is not empty. Clearing either bit ends the run at once: `sample_req` drops in the very next cycle and nothing is published.
- R6: At the end of the completion cycle, `touch_ready` (also bit 2 of offset 0x0C) goes to 1. Writing 1 to bit 2 of 0x0C clears it. Writing 0 to that bit leaves it unchanged.
- R7: While ready, successive reads of offset 0x18 return result pairs in list order. Entry 2p sits in bits 11:0 and entry 2p+1 in bits 27:16, and all other bits are 0. When the list has an odd length, the upper half of the last pair is 0. Reads past the last pair return 0.
- R8: A read of offset 0x18 while `touch_ready` is 0 returns 0.
- R9: After a completion, if the run conditions still hold, the next run starts straight away. Each completion republishes every result, sets ready and rewinds readout to the first pair.
- R10: Offsets 0x10 and 0x14 read back their 16-bit values and 0x04 reads back all 32 bits. Offset 0x00 reads back only bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; side effects take place at the clock edge |
| bus_addr | input | 6 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, 0 when no read is active |
| sample_data | input | 12 | Converter result for the current conversion cycle |
| sample_req | output | 1 | High in each conversion cycle |
| sample_cmd | output | 26 | Active command word for the front end |
| touch_ready | output | 1 | Published results are available |

## Verification
The bench goes after the edges of the list and the run. The first case is a list that overflows past six entries: a pointer that wraps or does not saturate would overwrite entry 0 and put the wrong command on the wire. The second is a terminator word that carries only upper garbage bits, which a full-width zero test would store as a command. The third is an odd-length list, where stale data from a previous run would leak into the upper half of the final pair. A sequencer that snapshots the settle count late, or that finishes a run after list mode is cleared, would show conversion strobes at the wrong cycles or raise ready after an abort. The cycle-level reference model exposes both, along with a readout pointer that fails to rewind when a repeated run completes.

// File: rtl/tsq_pkg.sv
package tsq_pkg;
    localparam int TSQ_SLOTS  = 6;
    localparam int TSQ_RES_W  = 12;
    localparam int TSQ_CMD_W  = 26;
    localparam int TSQ_CNT_W  = 16;
    localparam int TSQ_ADDR_W = 6;
    localparam int HI_LANE    = 16;

    localparam logic [TSQ_ADDR_W-1:0] OFF_ENABLE = 6'h00;
    localparam logic [TSQ_ADDR_W-1:0] OFF_CFG    = 6'h04;
    localparam logic [TSQ_ADDR_W-1:0] OFF_STATUS = 6'h0C;
    localparam logic [TSQ_ADDR_W-1:0] OFF_SAME   = 6'h10;
    localparam logic [TSQ_ADDR_W-1:0] OFF_WAIT   = 6'h14;
    localparam logic [TSQ_ADDR_W-1:0] OFF_TDATA  = 6'h18;
    localparam logic [TSQ_ADDR_W-1:0] OFF_CMD    = 6'h24;

    localparam int ENG_BIT       = 2;
    localparam int LIST_MODE_BIT = 22;
    localparam int READY_BIT     = 2;

    typedef enum logic [1:0] {
        SQ_IDLE   = 2'd0,
        SQ_SETTLE = 2'd1,
        SQ_CONV   = 2'd2,
        SQ_DONE   = 2'd3
    } sq_state_e;

    // number of packed result words needed for n entries
    function automatic int pairs_of(input int n);
        return (n + 1) / 2;
    endfunction
endpackage

// File: rtl/tsq_regs.sv
module tsq_regs
    import tsq_pkg::*;
#(
    parameter int SLOTS = TSQ_SLOTS,
    parameter int CMD_W = TSQ_CMD_W,
    parameter int CNT_W = TSQ_CNT_W,
    localparam int PTR_W = $clog2(SLOTS + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [TSQ_ADDR_W-1:0] bus_addr,
    input  logic [31:0]           bus_wdata,
    input  logic [31:0]           tdata_word,
    input  logic                  ready,
    output logic [31:0]           bus_rdata,
    output logic                  eng_en,
    output logic                  list_mode,
    output logic [CNT_W-1:0]      settle_len,
    output logic [CNT_W-1:0]      same_len,
    output logic [CMD_W-1:0]      cmd_list [SLOTS],
    output logic [PTR_W-1:0]      list_len,
    output logic                  ready_clr,
    output logic                  tdata_pop
);
    logic              en_q;
    logic [31:0]       cfg_q;
    logic [CNT_W-1:0]  same_q, wait_q;
    logic [PTR_W-1:0]  wptr_q, len_q;
    logic [CMD_W-1:0]  slot_q [SLOTS];
    logic              cmd_wr, cmd_rd, cmd_end;

    assign cmd_wr  = bus_wr && (bus_addr == OFF_CMD);
    assign cmd_rd  = bus_rd && (bus_addr == OFF_CMD);
    assign cmd_end = (bus_wdata[CMD_W-1:0] == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            cfg_q  <= '0;
            same_q <= '0;
            wait_q <= '0;
            wptr_q <= '0;
            len_q  <= '0;
            for (int i = 0; i < SLOTS; i++) slot_q[i] <= '0;
        end else begin
            if (bus_wr) begin
                case (bus_addr)
                    OFF_ENABLE: en_q   <= bus_wdata[ENG_BIT];
                    OFF_CFG:    cfg_q  <= bus_wdata;
                    OFF_SAME:   same_q <= bus_wdata[CNT_W-1:0];
                    OFF_WAIT:   wait_q <= bus_wdata[CNT_W-1:0];
                    default: ;
                endcase
            end
            if (cmd_wr) begin
                if (cmd_end) begin
                    len_q <= wptr_q;
                end else if (wptr_q < PTR_W'(SLOTS)) begin
                    slot_q[wptr_q] <= bus_wdata[CMD_W-1:0];
                    wptr_q         <= wptr_q + 1'b1;
                end
            end
            if (cmd_rd) wptr_q <= '0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (bus_addr)
                OFF_ENABLE: bus_rdata[ENG_BIT]   = en_q;
                OFF_CFG:    bus_rdata            = cfg_q;
                OFF_STATUS: bus_rdata[READY_BIT] = ready;
                OFF_SAME:   bus_rdata            = 32'(same_q);
                OFF_WAIT:   bus_rdata            = 32'(wait_q);
                OFF_TDATA:  bus_rdata            = tdata_word;
                default:    bus_rdata            = '0;
            endcase
        end
    end

    assign eng_en     = en_q;
    assign list_mode  = cfg_q[LIST_MODE_BIT];
    assign settle_len = wait_q;
    assign same_len   = same_q;
    assign list_len   = len_q;
    assign cmd_list   = slot_q;
    assign ready_clr  = bus_wr && (bus_addr == OFF_STATUS) && bus_wdata[READY_BIT];
    assign tdata_pop  = bus_rd && (bus_addr == OFF_TDATA);

    // R2: the append pointer never passes the list capacity
    assert_wptr_bound_R2: assert property (@(posedge clk) disable iff (rst)
        wptr_q <= PTR_W'(SLOTS));

    // R2: a closed list never claims more entries than capacity
    assert_len_bound_R2: assert property (@(posedge clk) disable iff (rst)
        len_q <= PTR_W'(SLOTS));
endmodule

// File: rtl/tsq_seq.sv
module tsq_seq
    import tsq_pkg::*;
#(
    parameter int SLOTS = TSQ_SLOTS,
    parameter int CMD_W = TSQ_CMD_W,
    parameter int CNT_W = TSQ_CNT_W,
    localparam int PTR_W = $clog2(SLOTS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic [CNT_W-1:0] settle_len,
    input  logic [CNT_W-1:0] same_len,
    input  logic [CMD_W-1:0] cmd_list [SLOTS],
    input  logic [PTR_W-1:0] list_len,
    output logic             sample_req,
    output logic [CMD_W-1:0] sample_cmd,
    output logic             cap_we,
    output logic [PTR_W-1:0] cap_idx,
    output logic [PTR_W-1:0] run_len,
    output logic             publish
);
    sq_state_e        state_q;
    logic [CNT_W-1:0] settle_q, rep_q;
    logic [PTR_W-1:0] idx_q, len_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= SQ_IDLE;
            settle_q <= '0;
            rep_q    <= '0;
            idx_q    <= '0;
            len_q    <= '0;
        end else if (!go) begin
            state_q <= SQ_IDLE;
        end else begin
            case (state_q)
                SQ_IDLE: begin
                    state_q  <= SQ_SETTLE;
                    settle_q <= settle_len;
                    len_q    <= list_len;
                end
                SQ_SETTLE: begin
                    if (settle_q == '0) begin
                        state_q <= SQ_CONV;
                        idx_q   <= '0;
                        rep_q   <= same_len;
                    end else begin
                        settle_q <= settle_q - 1'b1;
                    end
                end
                SQ_CONV: begin
                    if (rep_q == '0) begin
                        if (idx_q == len_q - 1'b1) begin
                            state_q <= SQ_DONE;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                            rep_q <= same_len;
                        end
                    end else begin
                        rep_q <= rep_q - 1'b1;
                    end
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    assign sample_req = (state_q == SQ_CONV) && go;
    assign sample_cmd = sample_req ? cmd_list[idx_q] : '0;
    assign cap_we     = sample_req;
    assign cap_idx    = idx_q;
    assign run_len    = len_q;
    assign publish    = (state_q == SQ_DONE) && go;

    // R3: a command on the wire is never the terminator value
    assert_cmd_nonzero_R3: assert property (@(posedge clk) disable iff (rst)
        sample_req |-> (sample_cmd != '0));

    // R4: conversion never addresses an entry beyond the run length
    assert_idx_bound_R4: assert property (@(posedge clk) disable iff (rst)
        sample_req |-> (idx_q < len_q));
endmodule

// File: rtl/tsq_resbuf.sv
module tsq_resbuf
    import tsq_pkg::*;
#(
    parameter int SLOTS = TSQ_SLOTS,
    parameter int RES_W = TSQ_RES_W,
    localparam int PTR_W = $clog2(SLOTS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cap_we,
    input  logic [PTR_W-1:0] cap_idx,
    input  logic [RES_W-1:0] sample_in,
    input  logic             publish,
    input  logic [PTR_W-1:0] run_len,
    input  logic             ready_clr,
    input  logic             tdata_pop,
    output logic             ready,
    output logic [31:0]      tdata_word
);
    logic [RES_W-1:0] cap_q [SLOTS];
    logic [RES_W-1:0] res_q [SLOTS];
    logic [PTR_W-1:0] pub_len_q, rptr_q, npairs, lo_ix, hi_ix;
    logic             ready_q, has_pair;

    always_comb begin
        npairs     = PTR_W'(pairs_of(int'(pub_len_q)));
        has_pair   = ready_q && (rptr_q < npairs);
        lo_ix      = PTR_W'({rptr_q, 1'b0});
        hi_ix      = lo_ix + 1'b1;
        tdata_word = '0;
        if (has_pair) begin
            tdata_word[RES_W-1:0] = res_q[lo_ix];
            if (hi_ix < pub_len_q) tdata_word[HI_LANE +: RES_W] = res_q[hi_ix];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SLOTS; i++) begin
                cap_q[i] <= '0;
                res_q[i] <= '0;
            end
            pub_len_q <= '0;
            rptr_q    <= '0;
            ready_q   <= 1'b0;
        end else begin
            if (cap_we) cap_q[cap_idx] <= sample_in;
            if (publish) begin
                for (int i = 0; i < SLOTS; i++) res_q[i] <= cap_q[i];
                pub_len_q <= run_len;
                rptr_q    <= '0;
                ready_q   <= 1'b1;
            end else begin
                if (ready_clr) ready_q <= 1'b0;
                if (tdata_pop && has_pair) rptr_q <= rptr_q + 1'b1;
            end
        end
    end

    assign ready = ready_q;

    // R7: readout never runs past the published pairs
    assert_pop_bound_R7: assert property (@(posedge clk) disable iff (rst)
        rptr_q <= npairs);
endmodule

// File: rtl/touch_cmd_seq.sv
module touch_cmd_seq
    import tsq_pkg::*;
#(
    parameter int SLOTS = TSQ_SLOTS,
    parameter int RES_W = TSQ_RES_W,
    parameter int CMD_W = TSQ_CMD_W,
    parameter int CNT_W = TSQ_CNT_W,
    localparam int PTR_W = $clog2(SLOTS + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [TSQ_ADDR_W-1:0] bus_addr,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rdata,
    input  logic [RES_W-1:0]      sample_data,
    output logic                  sample_req,
    output logic [CMD_W-1:0]      sample_cmd,
    output logic                  touch_ready
);
    logic             eng_en, list_mode, ready_clr, tdata_pop, go;
    logic             cap_we, publish;
    logic [CNT_W-1:0] settle_len, same_len;
    logic [CMD_W-1:0] cmd_list [SLOTS];
    logic [PTR_W-1:0] list_len, cap_idx, run_len;
    logic [31:0]      tdata_word;

    tsq_regs #(.SLOTS(SLOTS), .CMD_W(CMD_W), .CNT_W(CNT_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .tdata_word (tdata_word),
        .ready      (touch_ready),
        .bus_rdata  (bus_rdata),
        .eng_en     (eng_en),
        .list_mode  (list_mode),
        .settle_len (settle_len),
        .same_len   (same_len),
        .cmd_list   (cmd_list),
        .list_len   (list_len),
        .ready_clr  (ready_clr),
        .tdata_pop  (tdata_pop)
    );

    assign go = eng_en && list_mode && (list_len != '0);

    tsq_seq #(.SLOTS(SLOTS), .CMD_W(CMD_W), .CNT_W(CNT_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .go         (go),
        .settle_len (settle_len),
        .same_len   (same_len),
        .cmd_list   (cmd_list),
        .list_len   (list_len),
        .sample_req (sample_req),
        .sample_cmd (sample_cmd),
        .cap_we     (cap_we),
        .cap_idx    (cap_idx),
        .run_len    (run_len),
        .publish    (publish)
    );

    tsq_resbuf #(.SLOTS(SLOTS), .RES_W(RES_W)) u_resbuf (
        .clk        (clk),
        .rst        (rst),
        .cap_we     (cap_we),
        .cap_idx    (cap_idx),
        .sample_in  (sample_data),
        .publish    (publish),
        .run_len    (run_len),
        .ready_clr  (ready_clr),
        .tdata_pop  (tdata_pop),
        .ready      (touch_ready),
        .tdata_word (tdata_word)
    );

    // R5: no conversion strobe unless both enables are set
    assert_req_enabled_R5: assert property (@(posedge clk) disable iff (rst)
        sample_req |-> (eng_en && list_mode));

    // R6: ready only rises out of a completion cycle
    assert_ready_src_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(touch_ready) |-> $past(publish));

    // R8: result reads return zero while nothing is published
    assert_idle_data_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (tdata_pop && !touch_ready) |-> (bus_rdata == '0));
endmodule

// File: tb/touch_cmd_seq_tb.sv
module touch_cmd_seq_tb;
    localparam logic [5:0] A_EN = 6'h00, A_CFG = 6'h04, A_ST = 6'h0C, A_SAME = 6'h10,
                           A_WAIT = 6'h14, A_TD = 6'h18, A_CMD = 6'h24;
    localparam logic [31:0] CMASK = 32'h03FF_FFFF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [11:0] sample_data = '0;
    logic        sample_req;
    logic [25:0] sample_cmd;
    logic        touch_ready;

    int n_chk = 0, n_fail = 0, req_seen = 0, cyc = 0;

    always #4 clk = ~clk;

    touch_cmd_seq u_dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sample_data(sample_data),
        .sample_req(sample_req), .sample_cmd(sample_cmd), .touch_ready(touch_ready)
    );

    // behavioural reference state
    bit          m_en, m_ready;
    logic [31:0] m_cfg;
    int          m_same, m_wait, m_wptr, m_len, m_runlen, m_runw, m_publen, m_rptr, ph;
    logic [31:0] m_list [6];
    int          m_cap [6];
    int          m_res [6];

    function automatic bit m_go();
        return m_en && m_cfg[22] && (m_len != 0);
    endfunction

    function automatic bit exp_req();
        int lo = m_runw + 2;
        return m_go() && ph != 0 && ph >= lo && ph < lo + m_runlen * (m_same + 1);
    endfunction

    function automatic logic [25:0] exp_cmd();
        if (!exp_req()) return '0;
        return m_list[(ph - m_runw - 2) / (m_same + 1)][25:0];
    endfunction

    function automatic logic [31:0] m_word(input int p);
        logic [31:0] w = 32'(m_res[2 * p] & 12'hFFF);
        if (2 * p + 1 < m_publen) w |= 32'(m_res[2 * p + 1] & 12'hFFF) << 16;
        return w;
    endfunction

    function automatic logic [31:0] model_rd(input logic [5:0] a);
        case (a)
            A_EN:   return m_en ? 32'h4 : 32'h0;
            A_CFG:  return m_cfg;
            A_ST:   return m_ready ? 32'h4 : 32'h0;
            A_SAME: return 32'(m_same);
            A_WAIT: return 32'(m_wait);
            A_TD:   return (m_ready && m_rptr < (m_publen + 1) / 2) ? m_word(m_rptr) : 32'h0;
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_en = 0; m_ready = 0; m_cfg = '0; m_same = 0; m_wait = 0; m_wptr = 0;
            m_len = 0; m_runlen = 0; m_runw = 0; m_publen = 0; m_rptr = 0; ph = 0;
            for (int i = 0; i < 6; i++) begin m_list[i] = '0; m_cap[i] = 0; m_res[i] = 0; end
        end else begin
            bit pub, rdy_pre;
            int s1;
            pub = 0;
            rdy_pre = m_ready;
            s1 = m_same + 1;
            if (!m_go()) ph = 0;
            else if (ph == 0) begin ph = 1; m_runlen = m_len; m_runw = m_wait; end
            else if (ph == m_runw + 2 + m_runlen * s1) begin
                for (int i = 0; i < 6; i++) m_res[i] = m_cap[i];
                m_publen = m_runlen; m_rptr = 0; m_ready = 1; pub = 1; ph = 0;
            end else begin
                if (ph >= m_runw + 2) m_cap[(ph - m_runw - 2) / s1] = int'(sample_data);
                ph++;
            end
            if (bus_wr) begin
                case (bus_addr)
                    A_EN:   m_en = bus_wdata[2];
                    A_CFG:  m_cfg = bus_wdata;
                    A_SAME: m_same = int'(bus_wdata[15:0]);
                    A_WAIT: m_wait = int'(bus_wdata[15:0]);
                    A_ST:   if (bus_wdata[2] && !pub) m_ready = 0;
                    A_CMD: begin
                        if ((bus_wdata & CMASK) == 0) m_len = m_wptr;
                        else if (m_wptr < 6) begin m_list[m_wptr] = bus_wdata & CMASK; m_wptr++; end
                    end
                    default: ;
                endcase
            end
            if (bus_rd && bus_addr == A_CMD) m_wptr = 0;
            if (bus_rd && bus_addr == A_TD && !pub && rdy_pre && m_rptr < (m_publen + 1) / 2) m_rptr++;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the reference, away from the active edge
    always @(negedge clk) begin
        cyc++;
        sample_data <= 12'((cyc * 29 + 11) & 12'hFFF);
        if (!rst) begin
            chk("R4 sample_req", 32'(sample_req), 32'(exp_req()));
            chk("R3 sample_cmd", 32'(sample_cmd), 32'(exp_cmd()));
            chk("R6 touch_ready", 32'(touch_ready), 32'(m_ready));
            if (sample_req) req_seen++;
        end
    end

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, input string tag, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #2;
        d = bus_rdata;
        chk(tag, d, model_rd(a));
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_ready(input string tag);
        int n = 0;
        while (!touch_ready && n < 400) begin @(negedge clk); n++; end
        chk(tag, 32'(touch_ready), 32'h1);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 / R8 reset state
        rd(A_EN, "R1 enable", d);   chk("R1 enable literal", d, 32'h0);
        rd(A_CFG, "R1 cfg", d);     chk("R1 cfg literal", d, 32'h0);
        rd(A_ST, "R1 status", d);   chk("R1 status literal", d, 32'h0);
        rd(A_TD, "R8 tdata", d);    chk("R8 tdata literal", d, 32'h0);

        // R10 readback
        wr(A_SAME, 32'h0000_0001);
        wr(A_WAIT, 32'h0000_0003);
        wr(A_CFG, 32'h0044_1000);
        wr(A_EN, 32'h0000_00FF);
        rd(A_SAME, "R10 same", d);  chk("R10 same literal", d, 32'h1);
        rd(A_WAIT, "R10 wait", d);  chk("R10 wait literal", d, 32'h3);
        rd(A_CFG, "R10 cfg", d);    chk("R10 cfg literal", d, 32'h0044_1000);
        rd(A_EN, "R10 enable", d);  chk("R10 enable literal", d, 32'h4);

        // R5: empty list never converts
        req_seen = 0;
        repeat (30) @(negedge clk);
        chk("R5 empty list strobes", 32'(req_seen), 32'h0);
        wr(A_EN, 32'h0);

        // R2 / R3 / R4 / R7: four entries, garbage upper bits, garbage terminator
        rd(A_CMD, "R2 cmd read", d); chk("R2 cmd read literal", d, 32'h0);
        wr(A_CMD, 32'h0024_8100);
        wr(A_CMD, 32'h0011_8400);
        wr(A_CMD, 32'h0024_8080);
        wr(A_CMD, 32'hFC11_8200);
        wr(A_CMD, 32'hFC00_0000);
        wr(A_EN, 32'h4);
        wait_ready("R6 first run ready");
        wr(A_EN, 32'h0);
        rd(A_TD, "R7 pair0", d);
        rd(A_TD, "R7 pair1", d);
        rd(A_TD, "R7 past end", d); chk("R7 past end literal", d, 32'h0);

        // R6 clear semantics
        wr(A_ST, 32'h0);
        rd(A_ST, "R6 write0 keeps", d); chk("R6 write0 keeps literal", d, 32'h4);
        wr(A_ST, 32'h4);
        rd(A_ST, "R6 clear", d);        chk("R6 clear literal", d, 32'h0);
        rd(A_TD, "R8 not ready", d);    chk("R8 not ready literal", d, 32'h0);

        // R7 odd list, zero settle and single sample
        wr(A_SAME, 32'h0);
        wr(A_WAIT, 32'h0);
        rd(A_CMD, "R2 rewind", d);
        wr(A_CMD, 32'h0024_8100);
        wr(A_CMD, 32'h0011_8400);
        wr(A_CMD, 32'h0011_8200);
        wr(A_CMD, 32'h0);
        wr(A_EN, 32'h4);
        wait_ready("R6 odd run ready");
        wr(A_EN, 32'h0);
        rd(A_TD, "R7 odd pair0", d);
        rd(A_TD, "R7 odd pair1", d);
        chk("R7 odd upper half", d & 32'hFFFF_0000, 32'h0);
        rd(A_TD, "R7 odd past end", d); chk("R7 odd past end literal", d, 32'h0);

        // R2 overflow and R9 automatic repeat
        wr(A_ST, 32'h4);
        rd(A_CMD, "R2 rewind again", d);
        for (int i = 0; i < 8; i++) wr(A_CMD, 32'h0000_0100 + 32'(i));
        wr(A_CMD, 32'h0);
        wr(A_SAME, 32'h2);
        wr(A_EN, 32'h4);
        wait_ready("R9 first completion");
        wr(A_ST, 32'h4);
        wait_ready("R9 repeated completion");
        rd(A_TD, "R9 pair after repeat", d);
        wr(A_EN, 32'h0);
        rd(A_TD, "R2 full pair", d);
        rd(A_TD, "R2 full pair last", d);
        rd(A_TD, "R2 full past end", d);

        // R5 abort during settle
        wr(A_ST, 32'h4);
        wr(A_WAIT, 32'd20);
        wr(A_EN, 32'h4);
        repeat (6) @(negedge clk);
        wr(A_CFG, 32'h0);
        req_seen = 0;
        repeat (60) @(negedge clk);
        chk("R5 abort strobes", 32'(req_seen), 32'h0);
        chk("R5 abort no publish", 32'(touch_ready), 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule